// File: doc/BRIEF.md
# Branch Target and Delay-Slot Sequencer

This block sits in the fetch/execute path of a delayed-branch processor. It takes an instruction word that decode has already classified as a branch and forms the branch target. It also owns the three-deep program-counter chain. In that chain, `pc` is the instruction now retiring, `npc` is its delay slot and `nnpc` is the address after the slot.

Decode supplies a format select that picks how the target is formed. Three formats use a plain word displacement of 19, 22 or 30 bits. One format uses a 16-bit displacement split across two fields of the word. One format adds a signed 13-bit immediate to a register operand. Condition evaluation happens elsewhere and arrives as `taken`.

On each `advance` strobe the chain moves one instruction forward. Three outcomes are possible:
- A taken branch lets the delay slot run and then goes to the target.
- An untaken branch with `annul` set skips the delay slot.
- Otherwise the chain simply steps by four bytes.

`target` is combinational from `pc`, the instruction word, the format select and the register operand.

Top module: `branch_seq_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the chain loads `pc`=0, `npc`=4, `nnpc`=8.
- R2: At a clock edge with `advance` low, `pc`, `npc` and `nnpc` keep their values, whatever `taken` and `annul` are.
- R3: With `fmt_sel`=0, the displacement is instruction bits 18:0 with two zero bits appended below, sign-extended from its bit 20, and `target` = `pc` + displacement.
- R4: With `fmt_sel`=1, the displacement is bits 21:0 shifted left by two and sign-extended from its bit 23, and `target` = `pc` + displacement.
- R5: With `fmt_sel`=2, the displacement is bits 29:0 shifted left by two (32 bits), and `target` = `pc` + displacement.
- R6: With `fmt_sel`=3, an 18-bit displacement is formed as follows:
  - its bits 17:16 come from instruction bits 21:20;
  - its bits 15:2 come from instruction bits 13:0;
  - its bits 1:0 are zero.

  The value is sign-extended from bit 17, and `target` = `pc` + displacement. Instruction bits 19:14 do not affect the result.
- R7: With `fmt_sel`=4, `target` = `reg_operand` + sign-extended instruction bits 12:0.
- R8: On `advance` with `taken` low and `annul` low, `pc`←old `npc`, `npc`←old `nnpc`, `nnpc`←old `nnpc`+4.
- R9: On `advance` with `taken` low and `annul` high, the delay slot is skipped: `pc`←old `nnpc`, `npc`←old `nnpc`+4, `nnpc`←old `nnpc`+8.
- R10: On `advance` with `taken` high, the delay slot still runs, whatever `annul` is: `pc`←old `npc`, `npc`←`target`, `nnpc`←`target`+4.
- R11: All sums wrap modulo 2^32. For `fmt_sel` 0 to 3 with a word-aligned `pc`, `target` bits 1:0 are zero.
- R12: `fmt_sel` values 5 to 7 give a zero displacement, so `target` = `pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| advance | input | 1 | Step the PC chain at this edge |
| insn | input | 32 | Branch instruction word |
| fmt_sel | input | 3 | Target format: 0/1/2 word disp 19/22/30, 3 split, 4 register+imm13 |
| reg_operand | input | 32 | Register value for the register form |
| taken | input | 1 | Branch condition resolved true |
| annul | input | 1 | Annul bit of the branch |
| target | output | 32 | Computed branch target |
| pc | output | 32 | Address of the retiring instruction |
| npc | output | 32 | Address of the delay slot |
| nnpc | output | 32 | Address after the delay slot |

## Verification
Each word format is driven with a positive and a negative displacement. The negative cases show that sign extension starts at the right bit and not one bit off. A 30-bit displacement of minus four against a small `pc` checks that the sum wraps through zero.

The split format is fed garbage in the unused middle field and a set top bit in its high field. This separates correct field placement from a contiguous read.

The register form is tried with a negative and a positive immediate. The chain is stepped through the sequential, annulled-untaken and taken-with-annul cases, which tell the three update rules apart. An unused format code confirms a zero displacement.

// File: rtl/brsq_pkg.sv
// brsq_pkg: shared types and widths for the branch sequencer.
// Assumes a 32-bit address space with 4-byte instructions.
package brsq_pkg;
    localparam int XLEN     = 32;
    localparam int FMT_BITS = 3;

    typedef enum logic [FMT_BITS-1:0] {
        FMT_WORD_S = 3'd0,
        FMT_WORD_M = 3'd1,
        FMT_WORD_L = 3'd2,
        FMT_SPLIT  = 3'd3,
        FMT_REGIMM = 3'd4
    } brsq_fmt_e;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] npc;
        logic [XLEN-1:0] nnpc;
    } brsq_chain_t;
endpackage

// File: rtl/brsq_word_disp.sv
// brsq_word_disp: forms a byte displacement from the low BITS bits of an
// instruction word (word offset), scaled by four and sign-extended.
// Assumes BITS+2 <= XLEN.
module brsq_word_disp #(
    parameter int XLEN = 32,
    parameter int BITS = 19
) (
    input  logic [XLEN-1:0] insn,
    output logic [XLEN-1:0] disp
);
    localparam int EXT = XLEN - BITS - 2;

    generate
        if (EXT > 0) begin : g_ext
            // Replicate the field's top bit above the scaled field.
            always_comb disp = {{EXT{insn[BITS-1]}}, insn[BITS-1:0], 2'b00};
        end else begin : g_full
            // Field fills the word once scaled; no extension needed.
            always_comb disp = {insn[BITS-1:0], 2'b00};
        end
    endgenerate
endmodule

// File: rtl/brsq_target_calc.sv
// brsq_target_calc: picks the displacement for the selected format and
// adds it to the PC, or adds a 13-bit immediate to a register operand.
// Assumes the format select is stable while the target is consumed.
module brsq_target_calc
    import brsq_pkg::*;
#(
    parameter int W_SHORT = 19,
    parameter int W_MID   = 22,
    parameter int W_LONG  = 30,
    parameter int IMM_W   = 13,
    parameter int SPL_HI  = 2,
    parameter int SPL_LO  = 14
) (
    input  logic [XLEN-1:0]     pc,
    input  logic [XLEN-1:0]     insn,
    input  logic [FMT_BITS-1:0] fmt_sel,
    input  logic [XLEN-1:0]     reg_operand,
    output logic [XLEN-1:0]     target
);
    localparam int NWORD   = 3;
    localparam int SPL_W   = SPL_HI + SPL_LO + 2;
    localparam int SPL_HIP = 20;

    function automatic int word_bits(input int idx);
        return (idx == 0) ? W_SHORT : (idx == 1) ? W_MID : W_LONG;
    endfunction

    logic [XLEN-1:0] word_disp [NWORD];
    logic [SPL_W-1:0] split_raw;
    logic [XLEN-1:0] split_disp;
    logic [XLEN-1:0] imm_ext;
    logic [XLEN-1:0] disp;

    for (genvar gi = 0; gi < NWORD; gi++) begin : g_word
        brsq_word_disp #(.XLEN(XLEN), .BITS(word_bits(gi))) u_wd (
            .insn (insn),
            .disp (word_disp[gi])
        );
    end

    // Assemble the split displacement from its two separated fields.
    always_comb begin
        split_raw  = {insn[SPL_HIP+SPL_HI-1:SPL_HIP], insn[SPL_LO-1:0], 2'b00};
        split_disp = {{(XLEN-SPL_W){split_raw[SPL_W-1]}}, split_raw};
        imm_ext    = {{(XLEN-IMM_W){insn[IMM_W-1]}}, insn[IMM_W-1:0]};
    end

    // Select the displacement; unused codes give zero.
    always_comb begin
        case (fmt_sel)
            FMT_WORD_S: disp = word_disp[0];
            FMT_WORD_M: disp = word_disp[1];
            FMT_WORD_L: disp = word_disp[2];
            FMT_SPLIT:  disp = split_disp;
            default:    disp = '0;
        endcase
    end

    // Form the target from the PC or from the register operand.
    always_comb begin
        if (fmt_sel == FMT_REGIMM) target = reg_operand + imm_ext;
        else                       target = pc + disp;
    end

    always_comb begin
        if (pc[1:0] == 2'b00 && fmt_sel < FMT_REGIMM)
            AST_ALIGNED_TARGET: assert (target[1:0] == 2'b00); // R11
    end
endmodule

// File: rtl/brsq_pc_chain.sv
// brsq_pc_chain: holds PC, NPC and NNPC and advances them per the branch
// outcome. Assumes target is valid in any cycle where advance is high.
module brsq_pc_chain
    import brsq_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = '0,
    parameter int              STEP     = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            advance,
    input  logic            taken,
    input  logic            annul,
    input  logic [XLEN-1:0] target,
    output brsq_chain_t     chain
);
    localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

    brsq_chain_t nxt;

    // Choose the following chain state from the branch outcome.
    always_comb begin
        if (taken) begin
            nxt.pc   = chain.npc;
            nxt.npc  = target;
            nxt.nnpc = target + STEP_V;
        end else if (annul) begin
            nxt.pc   = chain.nnpc;
            nxt.npc  = chain.nnpc + STEP_V;
            nxt.nnpc = chain.nnpc + (STEP_V << 1);
        end else begin
            nxt.pc   = chain.npc;
            nxt.npc  = chain.nnpc;
            nxt.nnpc = chain.nnpc + STEP_V;
        end
    end

    // Register the chain on reset or on an advance strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain.pc   <= RESET_PC;
            chain.npc  <= RESET_PC + STEP_V;
            chain.nnpc <= RESET_PC + (STEP_V << 1);
        end else if (advance) begin
            chain <= nxt;
        end
    end

    AST_RESET_VALUES: assert property (@(posedge clk)
        $past(!rst_n) |-> chain.pc == RESET_PC && chain.npc == RESET_PC + STEP_V) // R1
        else $error("reset values");
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(advance) |-> $stable(chain)) // R2
        else $error("hold");
    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        advance && !taken && !annul |=>
        chain.pc == $past(chain.npc) && chain.npc == $past(chain.nnpc)) // R8
        else $error("seq");
    AST_ANNUL_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        advance && !taken && annul |=>
        chain.pc == $past(chain.nnpc) && chain.npc == chain.pc + STEP_V) // R9
        else $error("annul");
    AST_TAKEN_REDIRECT: assert property (@(posedge clk) disable iff (!rst_n)
        advance && taken |=>
        chain.pc == $past(chain.npc) && chain.npc == $past(target)) // R10
        else $error("taken");
endmodule

// File: rtl/branch_seq_unit.sv
// branch_seq_unit: top of the branch target and delay-slot sequencer.
// Computes the branch target combinationally from the current PC and
// steps the PC/NPC/NNPC chain on each advance strobe.
// Assumes decode has already classified the word and evaluated the condition.
module branch_seq_unit
    import brsq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                advance,
    input  logic [XLEN-1:0]     insn,
    input  logic [FMT_BITS-1:0] fmt_sel,
    input  logic [XLEN-1:0]     reg_operand,
    input  logic                taken,
    input  logic                annul,
    output logic [XLEN-1:0]     target,
    output logic [XLEN-1:0]     pc,
    output logic [XLEN-1:0]     npc,
    output logic [XLEN-1:0]     nnpc
);
    brsq_chain_t chain;

    brsq_target_calc u_tgt (
        .pc          (chain.pc),
        .insn        (insn),
        .fmt_sel     (fmt_sel),
        .reg_operand (reg_operand),
        .target      (target)
    );

    brsq_pc_chain u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (advance),
        .taken   (taken),
        .annul   (annul),
        .target  (target),
        .chain   (chain)
    );

    // Expose the chain registers as separate ports.
    always_comb begin
        pc   = chain.pc;
        npc  = chain.npc;
        nnpc = chain.nnpc;
    end
endmodule

// File: tb/sim_branch_seq_unit.sv
// sim_branch_seq_unit: directed bench, one task per scenario.
module sim_branch_seq_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        advance = 1'b0;
    logic [31:0] insn = '0;
    logic [2:0]  fmt_sel = '0;
    logic [31:0] reg_operand = '0;
    logic        taken = 1'b0;
    logic        annul = 1'b0;
    logic [31:0] target, pc, npc, nnpc;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] e_pc, e_npc, e_nnpc;

    always #2 clk = ~clk;

    branch_seq_unit u0 (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_chain(input string req);
        check({req, " pc"}, pc, e_pc);
        check({req, " npc"}, npc, e_npc);
        check({req, " nnpc"}, nnpc, e_nnpc);
    endtask

    // Word displacement computed arithmetically.
    function automatic logic [31:0] wdisp(input logic [31:0] w, input int n);
        longint v;
        v = longint'(w) & ((64'd1 << n) - 1);
        if (v >= (64'd1 << (n - 1))) v = v - (64'd1 << n);
        return 32'(v * 4);
    endfunction

    task automatic set_target(input logic [2:0] f, input logic [31:0] w, input logic [31:0] r);
        @(negedge clk);
        fmt_sel = f; insn = w; reg_operand = r;
        #1;
    endtask

    task automatic step(input logic t, input logic a);
        @(negedge clk);
        advance = 1'b1; taken = t; annul = a;
        @(negedge clk);
        advance = 1'b0; taken = 1'b0; annul = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        e_pc = 0; e_npc = 4; e_nnpc = 8;
        check_chain("R1");
    endtask

    task automatic t_hold();
        @(negedge clk);
        taken = 1'b1; annul = 1'b1;
        repeat (2) @(negedge clk);
        taken = 1'b0; annul = 1'b0;
        check_chain("R2");
    endtask

    task automatic t_seq();
        step(1'b0, 1'b0);
        e_pc = 4; e_npc = 8; e_nnpc = 12;
        check_chain("R8");
    endtask

    task automatic t_word();
        set_target(3'd0, 32'hFFF0_0010, 0);
        check("R3 pos", target, pc + wdisp(32'hFFF0_0010, 19));
        set_target(3'd0, 32'h0004_0000, 0);
        check("R3 neg", target, pc + wdisp(32'h0004_0000, 19));
        set_target(3'd1, 32'h0020_0003, 0);
        check("R4 neg", target, pc + wdisp(32'h0020_0003, 22));
        set_target(3'd1, 32'hFF1F_0000, 0);
        check("R4 pos", target, pc + wdisp(32'hFF1F_0000, 22));
        set_target(3'd2, 32'h0000_1234, 0);
        check("R5 pos", target, pc + 32'h48D0);
        set_target(3'd2, 32'h3FFF_FFFF, 0);
        check("R11 wrap", target, 32'h0);
        check("R11 align", {30'b0, target[1:0]}, 32'h0);
    endtask

    task automatic t_split();
        logic [31:0] w;
        longint v;
        w = 32'h002F_C005;
        v = 2 * 65536 + 5 * 4;
        v = v - 262144;
        set_target(3'd3, w, 0);
        check("R6 neg", target, pc + 32'(v));
        set_target(3'd3, 32'h001F_C3FF, 0);
        check("R6 pos", target, pc + 32'h1_0000 + 32'h0FFC);
    endtask

    task automatic t_regimm();
        set_target(3'd4, 32'hABCD_FFFF, 32'h0000_1000);
        check("R7 neg", target, 32'h0000_0FFF);
        set_target(3'd4, 32'h0000_0123, 32'h0000_2000);
        check("R7 pos", target, 32'h0000_2123);
    endtask

    task automatic t_unused();
        for (int f = 5; f < 8; f++) begin
            set_target(3'(f), 32'h1234_5678, 32'h9999_0000);
            check("R12", target, pc);
        end
    endtask

    task automatic t_taken();
        logic [31:0] tg;
        set_target(3'd1, 32'h0000_0040, 0);
        tg = pc + 32'h100;
        check("R4 taken tgt", target, tg);
        step(1'b1, 1'b1);
        e_pc = 8; e_npc = tg; e_nnpc = tg + 4;
        check_chain("R10");
    endtask

    task automatic t_annul();
        logic [31:0] b;
        b = nnpc;
        step(1'b0, 1'b1);
        e_pc = b; e_npc = b + 4; e_nnpc = b + 8;
        check_chain("R9");
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_hold();
                t_seq();
                t_word();
                t_split();
                t_regimm();
                t_unused();
                t_taken();
                t_annul();
            end
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule